// File: doc/BRIEF.md
# Page-Buffered EEPROM Write Engine

This block is the device-side control logic of a byte-wide parallel EEPROM, modelled in synchronous logic. It samples an active-low chip select, write strobe and output enable together with a 17-bit address and an 8-bit data bus on every clock. From these it decodes the bus mode, gathers written bytes into a 128-byte page buffer and holds a page window open that restarts on every write strobe. When the window expires, a self-timed programming phase starts. It copies the buffered bytes into a register-based storage array and answers reads with a polling byte until it completes.

The page window and the programming time are parameters counted in clock cycles, so a bench can use short values. The storage array holds `PAGES` pages. A page is chosen by the low bits of the address above the 7-bit byte offset, so higher address bits alias. Every output is registered. A bus state applied before clock edge N shows at `dout`/`dout_en` after edge N+1.

Top module: `eeprom_page_engine`

## Requirements
- R1: The sampled bus is a read only when chip select is low, output enable is low and write strobe is high. In that case `dout_en` is 1 two clock edges later. In any other mode `dout_en` is 0.
- R2: When `dout_en` is 0, `dout` is 0x00. This covers standby (chip select high), inhibit and write modes.
- R3: A write strobe exists while chip select and write strobe are both low with output enable high. The byte offset (address bits 6:0) is captured on the sample where the strobe begins, so either select or write can be the later falling control. Address changes during the strobe have no effect.
- R4: The data byte is the last value sampled while the strobe was still active. This means the earlier of the two rising controls ends capture, and data changed afterwards is not stored.
- R5: While output enable is low, holding select and write low stores nothing and opens no page window.
- R6: The page number comes from the first strobe of a window. Later strobes in the same window land at their own offset within that page, whatever their upper address bits. Only bytes loaded in the window change in the array.
- R7: Each strobe start restarts the page window of `WIN_CYC` cycles. Programming never starts while strobes keep arriving closer than the window.
- R8: When the window expires with no strobe active, a programming phase of `PROG_CYC` cycles runs. During it, every read returns a byte whose bit 7 is the complement of bit 7 of the last loaded byte and whose bits 6:0 are 0.
- R9: Write strobes that begin during programming are ignored. They store no byte and start no new window.
- R10: After reset every array byte reads 0xFF. After programming completes, reads return the stored bytes, and reads during loading return the old array contents.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sel_n | input | 1 | Chip select, active low |
| wr_n | input | 1 | Write strobe, active low |
| rd_n | input | 1 | Output enable, active low |
| addr | input | 17 | Byte address |
| din | input | 8 | Write data |
| dout | output | 8 | Read data, 0 when not driven |
| dout_en | output | 1 | Data bus drive enable |

## Verification
A wrong window counter or sequencer state shows at the ports as early polling bytes or as stale data. A read placed just inside the window returns the polling pattern instead of the old contents, and a read after the expected completion returns the polling pattern instead of the new byte. A wrong capture register for offset or data shows as the byte landing at a neighbouring offset, or carrying the post-strobe value, on the first readback after programming ends. Decode faults show two edges after the offending bus state, as `dout_en` asserted outside read mode or data appearing on a standby bus.

// File: rtl/epw_pkg.sv
package epw_pkg;

    typedef enum logic [1:0] {
        BUS_IDLE,
        BUS_READ,
        BUS_WRITE,
        BUS_HOLD
    } bus_mode_e;

    typedef enum logic [1:0] {
        SQ_IDLE,
        SQ_LOAD,
        SQ_PROG
    } seq_state_e;

    function automatic bus_mode_e decode_mode(input logic sel_n,
                                              input logic wr_n,
                                              input logic rd_n);
        if (sel_n)
            return BUS_IDLE;
        else if (!rd_n && wr_n)
            return BUS_READ;
        else if (!wr_n && rd_n)
            return BUS_WRITE;
        else
            return BUS_HOLD;
    endfunction

endpackage

// File: rtl/epw_strobe.sv
module epw_strobe
    import epw_pkg::*;
#(
    parameter int ADDR_W = 17,
    parameter int DATA_W = 8,
    parameter int OFS_W  = 7
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sel_n,
    input  logic              wr_n,
    input  logic              rd_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] din,
    output bus_mode_e         mode,
    output logic [ADDR_W-1:0] s_addr,
    output logic              stb_on,
    output logic              stb_fall,
    output logic              stb_end,
    output logic [OFS_W-1:0]  cap_ofs,
    output logic [DATA_W-1:0] cap_data
);

    logic              s_sel_n, s_wr_n, s_rd_n;
    logic [DATA_W-1:0] s_din;
    logic              stb_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            s_sel_n  <= 1'b1;
            s_wr_n   <= 1'b1;
            s_rd_n   <= 1'b1;
            s_addr   <= '0;
            s_din    <= '0;
            stb_q    <= 1'b0;
            cap_ofs  <= '0;
            cap_data <= '0;
        end else begin
            s_sel_n <= sel_n;
            s_wr_n  <= wr_n;
            s_rd_n  <= rd_n;
            s_addr  <= addr;
            s_din   <= din;
            stb_q   <= stb_on;
            // data follows the bus only while the strobe is still active
            if (stb_on)
                cap_data <= s_din;
            // offset is taken once, when the strobe first appears
            if (stb_fall)
                cap_ofs <= s_addr[OFS_W-1:0];
        end
    end

    always_comb begin
        mode     = decode_mode(s_sel_n, s_wr_n, s_rd_n);
        stb_on   = (mode == BUS_WRITE);
        stb_fall = stb_on && !stb_q;
        stb_end  = !stb_on && stb_q;
    end

endmodule

// File: rtl/epw_sequencer.sv
module epw_sequencer
    import epw_pkg::*;
#(
    parameter int WIN_CYC  = 18750,
    parameter int PROG_CYC = 1250000
) (
    input  logic clk,
    input  logic rst,
    input  logic stb_on,
    input  logic stb_fall,
    input  logic stb_end,
    output logic first_stb,
    output logic acc_end,
    output logic commit,
    output logic busy
);

    localparam int WC_W = (WIN_CYC  > 2) ? $clog2(WIN_CYC)  : 1;
    localparam int PC_W = (PROG_CYC > 2) ? $clog2(PROG_CYC) : 1;

    seq_state_e      state;
    logic [WC_W-1:0] win_cnt;
    logic [PC_W-1:0] prog_cnt;
    logic            acc_q;

    always_comb begin
        busy      = (state == SQ_PROG);
        first_stb = stb_fall && (state == SQ_IDLE);
        acc_end   = stb_end && acc_q;
        commit    = (state == SQ_LOAD) && (win_cnt == WC_W'(WIN_CYC - 1))
                    && !stb_on && !stb_end;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= SQ_IDLE;
            win_cnt  <= '0;
            prog_cnt <= '0;
            acc_q    <= 1'b0;
        end else begin
            if (stb_fall)
                acc_q <= !busy;
            unique case (state)
                SQ_IDLE: begin
                    if (stb_fall) begin
                        state   <= SQ_LOAD;
                        win_cnt <= '0;
                    end
                end
                SQ_LOAD: begin
                    if (stb_fall)
                        win_cnt <= '0;
                    else if (win_cnt != WC_W'(WIN_CYC - 1))
                        win_cnt <= win_cnt + 1'b1;
                    else if (commit) begin
                        state    <= SQ_PROG;
                        prog_cnt <= '0;
                    end
                end
                SQ_PROG: begin
                    if (prog_cnt == PC_W'(PROG_CYC - 1))
                        state <= SQ_IDLE;
                    else
                        prog_cnt <= prog_cnt + 1'b1;
                end
                default: state <= SQ_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/epw_store.sv
module epw_store #(
    parameter int DATA_W = 8,
    parameter int OFS_W  = 7,
    parameter int PAGES  = 4
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        first_stb,
    input  logic [$clog2(PAGES)-1:0]    page_in,
    input  logic                        wr_en,
    input  logic [OFS_W-1:0]            wr_ofs,
    input  logic [DATA_W-1:0]           wr_data,
    input  logic                        commit,
    input  logic                        busy,
    input  logic                        rd_mode,
    input  logic [$clog2(PAGES)+OFS_W-1:0] rd_idx,
    output logic [DATA_W-1:0]           dout,
    output logic                        dout_en
);

    localparam int PG_W       = $clog2(PAGES);
    localparam int PAGE_BYTES = 1 << OFS_W;
    localparam int DEPTH      = PAGES * PAGE_BYTES;

    logic [DATA_W-1:0] mem   [DEPTH];
    logic [DATA_W-1:0] latch [PAGE_BYTES];
    logic [PAGE_BYTES-1:0] vld;
    logic [PG_W-1:0]   page_q;
    logic [DATA_W-1:0] last_q;
    logic [DATA_W-1:0] poll;

    assign poll = {~last_q[DATA_W-1], {(DATA_W-1){1'b0}}};

    always_ff @(posedge clk) begin
        if (rst) begin
            vld    <= '0;
            page_q <= '0;
            last_q <= '0;
            for (int i = 0; i < PAGE_BYTES; i++)
                latch[i] <= '0;
            for (int j = 0; j < DEPTH; j++)
                mem[j] <= '1;
        end else begin
            if (first_stb)
                page_q <= page_in;
            if (wr_en) begin
                latch[wr_ofs] <= wr_data;
                vld[wr_ofs]   <= 1'b1;
                last_q        <= wr_data;
            end
            if (commit) begin
                for (int i = 0; i < PAGE_BYTES; i++)
                    if (vld[i])
                        mem[{page_q, OFS_W'(i)}] <= latch[i];
                vld <= '0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            dout    <= '0;
            dout_en <= 1'b0;
        end else begin
            dout_en <= rd_mode;
            if (!rd_mode)
                dout <= '0;
            else if (busy)
                dout <= poll;
            else
                dout <= mem[rd_idx];
        end
    end

endmodule

// File: rtl/eeprom_page_engine.sv
module eeprom_page_engine
    import epw_pkg::*;
#(
    parameter int ADDR_W   = 17,
    parameter int DATA_W   = 8,
    parameter int OFS_W    = 7,
    parameter int PAGES    = 4,
    parameter int WIN_CYC  = 18750,
    parameter int PROG_CYC = 1250000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sel_n,
    input  logic              wr_n,
    input  logic              rd_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout,
    output logic              dout_en
);

    localparam int PG_W  = $clog2(PAGES);
    localparam int IDX_W = PG_W + OFS_W;

    bus_mode_e         mode;
    logic [ADDR_W-1:0] s_addr;
    logic              stb_on, stb_fall, stb_end;
    logic [OFS_W-1:0]  cap_ofs;
    logic [DATA_W-1:0] cap_data;
    logic              first_stb, acc_end, commit, busy;
    logic              unused_addr_hi;

    assign unused_addr_hi = ^s_addr[ADDR_W-1:IDX_W];

    epw_strobe #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .OFS_W(OFS_W)) u_strobe (
        .clk(clk), .rst(rst), .sel_n(sel_n), .wr_n(wr_n), .rd_n(rd_n),
        .addr(addr), .din(din), .mode(mode), .s_addr(s_addr),
        .stb_on(stb_on), .stb_fall(stb_fall), .stb_end(stb_end),
        .cap_ofs(cap_ofs), .cap_data(cap_data)
    );

    epw_sequencer #(.WIN_CYC(WIN_CYC), .PROG_CYC(PROG_CYC)) u_seq (
        .clk(clk), .rst(rst), .stb_on(stb_on), .stb_fall(stb_fall),
        .stb_end(stb_end), .first_stb(first_stb), .acc_end(acc_end),
        .commit(commit), .busy(busy)
    );

    epw_store #(.DATA_W(DATA_W), .OFS_W(OFS_W), .PAGES(PAGES)) u_store (
        .clk(clk), .rst(rst), .first_stb(first_stb),
        .page_in(s_addr[IDX_W-1:OFS_W]), .wr_en(acc_end),
        .wr_ofs(cap_ofs), .wr_data(cap_data), .commit(commit), .busy(busy),
        .rd_mode(mode == BUS_READ), .rd_idx(s_addr[IDX_W-1:0]),
        .dout(dout), .dout_en(dout_en)
    );

endmodule

// File: rtl/epw_checker.sv
module epw_checker #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              sel_n,
    input logic              wr_n,
    input logic              rd_n,
    input logic [DATA_W-1:0] dout,
    input logic              dout_en,
    input logic              stb_fall,
    input logic              acc_end,
    input logic              commit,
    input logic              busy
);

    assert_read_enable_R1: assert property (@(posedge clk) disable iff (rst)
        dout_en == $past(!sel_n && !rd_n && wr_n, 2));

    assert_quiet_bus_R2: assert property (@(posedge clk) disable iff (rst)
        !dout_en |-> (dout == '0));

    assert_commit_enters_prog_R8: assert property (@(posedge clk) disable iff (rst)
        commit |=> busy);

    assert_prog_from_commit_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(commit));

    assert_no_store_in_prog_R9: assert property (@(posedge clk) disable iff (rst)
        busy |-> !acc_end);

    assert_window_quiet_R7: assert property (@(posedge clk) disable iff (rst)
        commit |-> !$past(stb_fall));

endmodule

bind eeprom_page_engine epw_checker #(.DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst(rst), .sel_n(sel_n), .wr_n(wr_n), .rd_n(rd_n),
    .dout(dout), .dout_en(dout_en), .stb_fall(stb_fall), .acc_end(acc_end),
    .commit(commit), .busy(busy)
);

// File: tb/eeprom_page_engine_tb.sv
module eeprom_page_engine_tb;

    localparam int WIN   = 20;
    localparam int PROG  = 40;
    localparam int PAGES = 4;
    localparam int DEPTH = PAGES * 128;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        sel_n = 1'b1, wr_n = 1'b1, rd_n = 1'b1;
    logic [16:0] addr = '0;
    logic [7:0]  din = '0;
    logic [7:0]  dout;
    logic        dout_en;

    int checks = 0;
    int errors = 0;

    logic [7:0] model [DEPTH];
    logic [7:0] pend  [128];
    logic       pend_v [128];
    logic [1:0] pend_pg;
    logic       pend_open;
    logic [7:0] last_b;

    always #4 clk = ~clk;

    eeprom_page_engine #(.PAGES(PAGES), .WIN_CYC(WIN), .PROG_CYC(PROG)) u_dut (
        .clk(clk), .rst(rst), .sel_n(sel_n), .wr_n(wr_n), .rd_n(rd_n),
        .addr(addr), .din(din), .dout(dout), .dout_en(dout_en)
    );

    function automatic logic [7:0] poll_of(input logic [7:0] b);
        return {~b[7], 7'b0};
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic bus_idle();
        sel_n = 1'b1; wr_n = 1'b1; rd_n = 1'b1;
    endtask

    task automatic note_byte(input logic [16:0] a, input logic [7:0] d);
        if (!pend_open) begin
            pend_open = 1'b1;
            pend_pg   = a[8:7];
        end
        pend[a[6:0]]   = d;
        pend_v[a[6:0]] = 1'b1;
        last_b         = d;
    endtask

    task automatic apply_pend();
        for (int i = 0; i < 128; i++) begin
            if (pend_v[i]) model[{pend_pg, 7'(i)}] = pend[i];
            pend_v[i] = 1'b0;
        end
        pend_open = 1'b0;
    endtask

    task automatic we_write(input logic [16:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; din = d; rd_n = 1'b1; sel_n = 1'b0; wr_n = 1'b0;
        repeat (2) @(negedge clk);
        wr_n = 1'b1; sel_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic settle();
        repeat (WIN + PROG + 10) @(negedge clk);
        apply_pend();
    endtask

    task automatic read_chk(input logic [16:0] a, input logic [7:0] exp, input string req);
        @(negedge clk);
        addr = a; sel_n = 1'b0; wr_n = 1'b1; rd_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        chk(dout_en === 1'b1 && dout === exp, req, {dout_en, dout}, {1'b1, exp});
        bus_idle();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 150000, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        logic [16:0] a, b;
        logic [7:0]  d;
        for (int i = 0; i < DEPTH; i++) model[i] = 8'hFF;
        for (int i = 0; i < 128; i++) pend_v[i] = 1'b0;
        pend_open = 1'b0;
        pend_pg   = '0;
        last_b    = '0;
        void'($urandom(32'd4242));

        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(dout_en === 1'b0 && dout === 8'h00, "R2 reset", {dout_en, dout}, 0);
        read_chk(17'h00000, 8'hFF, "R10 erased after reset");

        // R2: standby and inhibit do not drive
        @(negedge clk); sel_n = 1'b1; rd_n = 1'b0; wr_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(dout_en === 1'b0 && dout === 8'h00, "R2 standby", {dout_en, dout}, 0);
        sel_n = 1'b0; rd_n = 1'b0; wr_n = 1'b0;
        repeat (2) @(negedge clk);
        chk(dout_en === 1'b0 && dout === 8'h00, "R1 no read when inhibited", {dout_en, dout}, 0);
        // R5: inhibit held several cycles, then nothing stored and no window
        din = 8'h5A; addr = 17'h00010;
        repeat (4) @(negedge clk);
        bus_idle();
        read_chk(17'h00010, model[17'h010], "R5 inhibit no window");
        repeat (WIN + PROG + 10) @(negedge clk);
        read_chk(17'h00010, model[17'h010], "R5 inhibit nothing stored");

        // R8, R10: load two bytes, poll during programming, data after
        we_write(17'h00083, 8'h3C); note_byte(17'h00083, 8'h3C);
        we_write(17'h00084, 8'hA7); note_byte(17'h00084, 8'hA7);
        repeat (WIN / 2) @(negedge clk);
        read_chk(17'h00083, model[17'h083], "R10 old data while loading");
        repeat (WIN / 2 + 8) @(negedge clk);
        read_chk(17'h00000, poll_of(last_b), "R8 polling byte");
        settle();
        read_chk(17'h00083, model[17'h083], "R10 stored byte");
        read_chk(17'h00084, model[17'h084], "R10 stored byte 2");
        read_chk(17'h00085, model[17'h085], "R6 unloaded byte unchanged");

        // R7: retrigger keeps window open
        we_write(17'h00101, 8'h11); note_byte(17'h00101, 8'h11);
        repeat (WIN - 6) @(negedge clk);
        we_write(17'h00102, 8'h92); note_byte(17'h00102, 8'h92);
        repeat (WIN - 8) @(negedge clk);
        read_chk(17'h00101, model[17'h101], "R7 still loading after retrigger");
        repeat (12) @(negedge clk);
        read_chk(17'h00101, poll_of(8'h92), "R7 programming after quiet window");
        settle();
        read_chk(17'h00101, model[17'h101], "R7 first byte kept");
        read_chk(17'h00102, model[17'h102], "R7 second byte kept");

        // R3, R4: select-controlled write, address and data moves ignored
        @(negedge clk); rd_n = 1'b1; wr_n = 1'b0; sel_n = 1'b1; addr = 17'h00190; din = 8'h01;
        @(negedge clk); addr = 17'h00195; din = 8'hC4; sel_n = 1'b0;
        @(negedge clk); addr = 17'h0019A;
        @(negedge clk); sel_n = 1'b1;
        @(negedge clk); din = 8'h77;
        @(negedge clk); wr_n = 1'b1;
        note_byte(17'h00195, 8'hC4);
        settle();
        read_chk(17'h00195, 8'hC4, "R3 R4 select-controlled byte");
        read_chk(17'h00190, model[17'h190], "R3 early address unused");
        read_chk(17'h0019A, model[17'h19A], "R3 late address unused");

        // R6: second strobe with another page lands in the first page
        we_write(17'h00085, 8'h6E); note_byte(17'h00085, 8'h6E);
        we_write(17'h00109, 8'h2B); note_byte(17'h00109, 8'h2B);
        settle();
        read_chk(17'h00089, 8'h2B, "R6 offset in first page");
        read_chk(17'h00109, model[17'h109], "R6 other page untouched");

        // R9: strobe during programming ignored
        we_write(17'h00020, 8'h44); note_byte(17'h00020, 8'h44);
        repeat (WIN + 8) @(negedge clk);
        we_write(17'h00030, 8'hE1);
        settle();
        read_chk(17'h00020, 8'h44, "R9 earlier byte stored");
        read_chk(17'h00030, model[17'h030], "R9 ignored strobe not stored");
        read_chk(17'h00031, model[17'h031], "R9 no new window");

        // random rounds
        for (int r = 0; r < 6; r++) begin
            int n;
            logic [16:0] base;
            logic [16:0] wl [8];
            n = 1 + int'($urandom_range(5));
            base = 17'($urandom);
            for (int k = 0; k < n; k++) begin
                a = {base[16:7], 7'($urandom)};
                d = 8'($urandom);
                wl[k] = a;
                we_write(a, d); note_byte(a, d);
            end
            repeat (WIN + 8) @(negedge clk);
            read_chk(17'($urandom), poll_of(last_b), "R8 random poll");
            settle();
            for (int k = 0; k < n; k++)
                read_chk(wl[k], model[wl[k][8:0]], "R6 random readback");
            b = 17'($urandom);
            read_chk(b, model[b[8:0]], "R10 random other address");
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule